// File: doc/BRIEF.md
# Selector-Addressed Configuration Item Reader

This block lets a host read a fixed set of byte-string configuration items through two small registers. The host first writes a 16-bit key to a selector register, which picks one item from one of two banks: a generic bank and a bank reserved for architecture-specific items. It then reads the item through a data register. Each data read returns one to eight bytes, and the read position moves forward by itself, so firmware can walk through an item with a string of identical reads.

Item lengths and contents come from an on-chip read-only table that is computed, not loaded. A read that runs past the end of an item is padded with zero bytes. A key whose index is out of range leaves no item selected, and every later read returns zero. A parameter picks one of two register layouts. The split layout has a selector register and a data register at separate addresses. The combined layout puts a byte-wide data port on top of the 16-bit selector port.

Top module: `cfg_item_reader`

## Requirements
- R1: In the selector key, bit 14 (`BANK_BIT`) picks the bank (0 generic, 1 architecture-local) and bits 13:0 are the entry index. Key bit 15 is ignored.
- R2: An index at or above `FIXED_ITEMS + FILE_SLOTS` (8 by default) leaves no item selected. Every data read then returns all zeros until the next in-range select.
- R3: Every select sets the read position to zero, including a repeat select of the current item.
- R4: A data read of N bytes (N = 1, 2, 4 or 8 on `req_size`) places the byte at the current position in the most significant of the low N byte lanes of `resp_rdata`. The following bytes go in the lanes below it. Lanes above N are zero, and the position moves forward by N.
- R5: When an item ends partway through a read, the remaining lower lanes are zero and the position stops at the item length.
- R6: After reset, bank 0 entry 0 is selected at position 0. This item is the 4-byte signature `SIG` (default 0x43464731), read from the high byte down.
- R7: Writes to the data register complete without error and change neither the read position nor any item content.
- R8: Split layout (`COMBINED=0`), where `req_addr` 0 is the selector and 1 is the data register:
  - The selector accepts only 2-byte writes. Any other selector access is flagged on `resp_err` with zero data.
  - A data access whose size is not 1, 2, 4 or 8 is also flagged.
- R9: Combined layout (`COMBINED=1`):
  - Any 1-byte access at either address reaches the data register.
  - A 2-byte write at address 0 selects an item.
  - Every other access is flagged on `resp_err` with zero data and has no effect.
- R10: Item contents:
  - Bank 0 entry 0 is the signature.
  - Every other item has length `(5*index + 3*bank) mod (MAX_LEN+1)`, where `MAX_LEN` is 12 by default.
  - Its byte at position p is `(128*bank + 16*index + p) mod 256`.
- R11: Every accepted request (`req_ready` is always 1) gets exactly one response in the cycle after it. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Always 1: one request taken per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | Register offset within the block |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data; the selector key is in bits 15:0 |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_rdata | output | 64 | Read data, right-aligned to the access size |
| resp_err | output | 1 | Access rejected |

## Verification
The assertions assume that `req_size` and `req_addr` stay stable only during the cycle the request is taken. They also assume that reset is applied before the first request, since the position checks compare against the length of the item currently selected. The bench drives each request for exactly one cycle, away from the clock edge, and leaves the bus idle between requests. It sweeps every index of both banks at every legal size, reading past the item end each time. It also sends out-of-range keys and illegal sizes, but only as single isolated accesses, so each rejection can be seen on its own.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

   // Decoded action for one accepted request; at most one flag is set.
   typedef struct packed {
      logic sel;   // load a new key
      logic rd;    // stream item bytes out
      logic ign;   // data write, accepted with no effect
      logic rej;   // illegal access, error response
   } acc_t;

   function automatic logic size_is_lane_count(input int unsigned sz, input int unsigned max_bytes);
      return (sz != 0) && ((sz & (sz - 1)) == 0) && (sz <= max_bytes);
   endfunction

endpackage

// File: rtl/cfg_item_decode.sv
module cfg_item_decode
   import cfg_item_pkg::*;
#(
   parameter int COMBINED   = 0,
   parameter int SIZE_W     = 4,
   parameter int DATA_BYTES = 8
) (
   input  logic              valid_i,
   input  logic              write_i,
   input  logic              addr_i,
   input  logic [SIZE_W-1:0] size_i,
   output acc_t              acc_o
);

   generate
      if (COMBINED != 0) begin : g_combined
         always_comb begin
            acc_o = '0;
            if (valid_i) begin
               if (size_i == SIZE_W'(1)) begin
                  if (write_i) acc_o.ign = 1'b1;
                  else         acc_o.rd  = 1'b1;
               end else if (size_i == SIZE_W'(2) && write_i && !addr_i) begin
                  acc_o.sel = 1'b1;
               end else begin
                  acc_o.rej = 1'b1;
               end
            end
         end
      end else begin : g_split
         logic size_ok;
         assign size_ok = size_is_lane_count(int'(size_i), DATA_BYTES);
         always_comb begin
            acc_o = '0;
            if (valid_i) begin
               if (!addr_i) begin
                  if (write_i && size_i == SIZE_W'(2)) acc_o.sel = 1'b1;
                  else                                 acc_o.rej = 1'b1;
               end else if (size_ok) begin
                  if (write_i) acc_o.ign = 1'b1;
                  else         acc_o.rd  = 1'b1;
               end else begin
                  acc_o.rej = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cfg_item_len.sv
module cfg_item_len #(
   parameter int IDX_W   = 3,
   parameter int OFF_W   = 5,
   parameter int MAX_LEN = 12
) (
   input  logic             bank_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [OFF_W-1:0] len_o
);

   int tmp;

   always_comb begin
      if (!bank_i && idx_i == '0) tmp = 4;
      else tmp = (int'(idx_i) * 5 + (bank_i ? 3 : 0)) % (MAX_LEN + 1);
      len_o = OFF_W'(tmp);
   end

endmodule

// File: rtl/cfg_item_rom.sv
module cfg_item_rom #(
   parameter int          IDX_W = 3,
   parameter int          OFF_W = 5,
   parameter logic [31:0] SIG   = 32'h43464731
) (
   input  logic             bank_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [OFF_W-1:0] off_i,
   output logic [7:0]       byte_o
);

   int          tmp;
   logic [31:0] sig_sh;

   always_comb begin
      tmp    = (bank_i ? 128 : 0) + int'(idx_i) * 16 + int'(off_i);
      sig_sh = '0;
      if (int'(off_i) < 4) sig_sh = SIG >> (8 * (3 - int'(off_i)));
      if (!bank_i && idx_i == '0) byte_o = sig_sh[7:0];
      else                        byte_o = tmp[7:0];
   end

endmodule

// File: rtl/cfg_item_cursor.sv
module cfg_item_cursor #(
   parameter int KEY_W    = 16,
   parameter int BANK_BIT = 14,
   parameter int ENTRIES  = 8,
   parameter int IDX_W    = 3,
   parameter int OFF_W    = 5,
   parameter int SIZE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_sel_i,
   input  logic [KEY_W-1:0]  key_i,
   input  logic              do_rd_i,
   input  logic [SIZE_W-1:0] rd_size_i,
   input  logic [OFF_W-1:0]  item_len_i,
   output logic              cur_ok_o,
   output logic              cur_bank_o,
   output logic [IDX_W-1:0]  cur_idx_o,
   output logic [OFF_W-1:0]  cur_off_o
);

   logic             in_range;
   logic [OFF_W:0]   sum;
   logic [OFF_W-1:0] nxt_off;
   logic             unused_key_hi;

   assign unused_key_hi = ^key_i[KEY_W-1:BANK_BIT+1];
   assign in_range      = key_i[BANK_BIT-1:0] < BANK_BIT'(ENTRIES);
   assign sum           = {1'b0, cur_off_o} + (OFF_W+1)'(rd_size_i);
   assign nxt_off       = (sum > {1'b0, item_len_i}) ? item_len_i : sum[OFF_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_ok_o   <= 1'b1;
         cur_bank_o <= 1'b0;
         cur_idx_o  <= '0;
         cur_off_o  <= '0;
      end else if (do_sel_i) begin
         cur_ok_o   <= in_range;
         cur_bank_o <= key_i[BANK_BIT];
         cur_idx_o  <= key_i[IDX_W-1:0];
         cur_off_o  <= '0;
      end else if (do_rd_i && cur_ok_o) begin
         cur_off_o  <= nxt_off;
      end
   end

   AST_SELECT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      do_sel_i |=> cur_off_o == '0);                                         // R3
   AST_OFF_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      (do_rd_i && !do_sel_i) |=> cur_off_o >= $past(cur_off_o));             // R4
   AST_OFF_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      cur_ok_o |-> cur_off_o <= item_len_i);                                 // R5
   AST_INVALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!cur_ok_o && !do_sel_i) |=> !cur_ok_o);                               // R2

endmodule

// File: rtl/cfg_item_reader.sv
module cfg_item_reader
   import cfg_item_pkg::*;
#(
   parameter int          COMBINED    = 0,
   parameter int          KEY_W       = 16,
   parameter int          BANK_BIT    = 14,
   parameter int          FIXED_ITEMS = 4,
   parameter int          FILE_SLOTS  = 4,
   parameter int          MAX_LEN     = 12,
   parameter int          DATA_BYTES  = 8,
   parameter int          SIZE_W      = 4,
   parameter logic [31:0] SIG         = 32'h43464731
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_write,
   input  logic                    req_addr,
   input  logic [SIZE_W-1:0]       req_size,
   input  logic [8*DATA_BYTES-1:0] req_wdata,
   output logic                    resp_valid,
   output logic [8*DATA_BYTES-1:0] resp_rdata,
   output logic                    resp_err
);

   localparam int ENTRIES = FIXED_ITEMS + FILE_SLOTS;
   localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int OFF_W   = $clog2(MAX_LEN + DATA_BYTES + 1);
   localparam int DATA_W  = 8 * DATA_BYTES;

   initial begin
      AST_PARAM_BANK_BIT: assert (BANK_BIT >= IDX_W && BANK_BIT <= KEY_W - 2)
         else $error("BANK_BIT out of range");                               // R1
      AST_PARAM_MAX_LEN: assert (MAX_LEN >= 4)
         else $error("MAX_LEN must hold the signature");                     // R6
      AST_PARAM_LANES: assert (DATA_BYTES >= 1 && DATA_BYTES < (1 << SIZE_W))
         else $error("DATA_BYTES does not fit req_size");                    // R4
   end

   acc_t             acc;
   logic             cur_ok;
   logic             cur_bank;
   logic [IDX_W-1:0] cur_idx;
   logic [OFF_W-1:0] cur_off;
   logic [OFF_W-1:0] item_len;
   logic [7:0]       lane_b [DATA_BYTES];
   logic [DATA_W-1:0] pack;
   logic             unused_wdata;

   assign req_ready    = 1'b1;
   assign unused_wdata = ^req_wdata[DATA_W-1:KEY_W];

   cfg_item_decode #(
      .COMBINED(COMBINED), .SIZE_W(SIZE_W), .DATA_BYTES(DATA_BYTES)
   ) u_decode (
      .valid_i(req_valid), .write_i(req_write), .addr_i(req_addr),
      .size_i(req_size), .acc_o(acc)
   );

   cfg_item_cursor #(
      .KEY_W(KEY_W), .BANK_BIT(BANK_BIT), .ENTRIES(ENTRIES),
      .IDX_W(IDX_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
   ) u_cursor (
      .clk(clk), .rst_n(rst_n),
      .do_sel_i(acc.sel), .key_i(req_wdata[KEY_W-1:0]),
      .do_rd_i(acc.rd), .rd_size_i(req_size), .item_len_i(item_len),
      .cur_ok_o(cur_ok), .cur_bank_o(cur_bank), .cur_idx_o(cur_idx), .cur_off_o(cur_off)
   );

   cfg_item_len #(
      .IDX_W(IDX_W), .OFF_W(OFF_W), .MAX_LEN(MAX_LEN)
   ) u_len (
      .bank_i(cur_bank), .idx_i(cur_idx), .len_o(item_len)
   );

   // One byte lookup per output lane; lanes past the item end read as zero.
   for (genvar j = 0; j < DATA_BYTES; j++) begin : g_lane
      logic [OFF_W-1:0] lane_off;
      logic [7:0]       lane_raw;
      assign lane_off = cur_off + OFF_W'(j);
      cfg_item_rom #(
         .IDX_W(IDX_W), .OFF_W(OFF_W), .SIG(SIG)
      ) u_rom (
         .bank_i(cur_bank), .idx_i(cur_idx), .off_i(lane_off), .byte_o(lane_raw)
      );
      assign lane_b[j] = (lane_off < item_len) ? lane_raw : 8'h00;
   end

   // First item byte lands in the highest of the requested low lanes.
   always_comb begin
      pack = '0;
      for (int j = 0; j < DATA_BYTES; j++) begin
         if (j < int'(req_size))
            pack |= DATA_W'(lane_b[j]) << (8 * (int'(req_size) - 1 - j));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_rdata <= '0;
      end else begin
         resp_valid <= req_valid;
         resp_err   <= acc.rej;
         resp_rdata <= (acc.rd && cur_ok) ? pack : '0;
      end
   end

   AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);                                             // R11
   AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !resp_valid);                                           // R11
   AST_REJECT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      resp_err |-> resp_rdata == '0);                                        // R8
   AST_DEAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.rd && !cur_ok) |=> resp_rdata == '0);                             // R2

endmodule

// File: tb/cfg_item_reader_bench.sv
`timescale 1ns/1ps
module cfg_item_reader_bench;

   localparam logic [31:0] SIG     = 32'h43464731;
   localparam int          MAX_LEN = 12;
   localparam int          ENTRIES = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        v_sep = 1'b0, v_comb = 1'b0;
   logic        r_wr = 1'b0, r_addr = 1'b0;
   logic [3:0]  r_size = 4'd0;
   logic [63:0] r_wdata = '0;
   logic        s_rdy, s_rv, s_err, c_rdy, c_rv, c_err;
   logic [63:0] s_rdata, c_rdata;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // model of the split instance
   int m_b, m_i, m_off;
   bit m_ok;

   always #10 clk = ~clk;

   cfg_item_reader #(.COMBINED(0), .SIG(SIG), .MAX_LEN(MAX_LEN)) u_cfg_item_reader (
      .clk(clk), .rst_n(rst_n), .req_valid(v_sep), .req_ready(s_rdy),
      .req_write(r_wr), .req_addr(r_addr), .req_size(r_size), .req_wdata(r_wdata),
      .resp_valid(s_rv), .resp_rdata(s_rdata), .resp_err(s_err));

   cfg_item_reader #(.COMBINED(1), .SIG(SIG), .MAX_LEN(MAX_LEN)) u_cfg_item_reader_comb (
      .clk(clk), .rst_n(rst_n), .req_valid(v_comb), .req_ready(c_rdy),
      .req_write(r_wr), .req_addr(r_addr), .req_size(r_size), .req_wdata(r_wdata),
      .resp_valid(c_rv), .resp_rdata(c_rdata), .resp_err(c_err));

   function automatic int e_len(int b, int i);
      if (b == 0 && i == 0) return 4;
      return (i * 5 + b * 3) % (MAX_LEN + 1);
   endfunction

   function automatic logic [7:0] e_byte(int b, int i, int o);
      logic [31:0] s;
      if (b == 0 && i == 0) begin
         s = SIG >> (8 * (3 - o));
         return s[7:0];
      end
      return 8'(b * 128 + i * 16 + o);
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xfer(input bit comb, input bit wr, input bit adr, input int sz,
                       input logic [63:0] wd, output logic [63:0] rd, output bit er);
      logic rv;
      @(negedge clk);
      v_sep = !comb; v_comb = comb;
      r_wr = wr; r_addr = adr; r_size = 4'(sz); r_wdata = wd;
      @(negedge clk);
      v_sep = 1'b0; v_comb = 1'b0;
      if (comb) begin rd = c_rdata; er = c_err; rv = c_rv; end
      else      begin rd = s_rdata; er = s_err; rv = s_rv; end
      chk("R11 response one cycle later", 64'(rv), 64'd1);
   endtask

   task automatic sel_sep(input int key);
      logic [63:0] rd; bit er;
      xfer(1'b0, 1'b1, 1'b0, 2, 64'(key), rd, er);
      chk("R1 select accepted", 64'(er), 64'd0);
      m_b = (key >> 14) & 1; m_i = key & 16'h3fff; m_off = 0; m_ok = (m_i < ENTRIES);
   endtask

   task automatic read_sep(input int sz, input string tag);
      logic [63:0] rd, exp; bit er; int ln;
      exp = '0;
      ln = m_ok ? e_len(m_b, m_i) : 0;
      for (int k = 0; k < sz; k++) begin
         logic [7:0] b;
         b = 8'h00;
         if (m_ok && m_off < ln) begin b = e_byte(m_b, m_i, m_off); m_off++; end
         exp = (exp << 8) | 64'(b);
      end
      xfer(1'b0, 1'b0, 1'b1, sz, '0, rd, er);
      chk(tag, rd, exp);
      chk({tag, " no error"}, 64'(er), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] rd; bit er;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset: no response", 64'({s_rv, c_rv, s_err, c_err}), 64'd0);
      chk("R11 ready", 64'({s_rdy, c_rdy}), 64'd3);

      // R6: reset selects the signature item
      m_b = 0; m_i = 0; m_off = 0; m_ok = 1'b1;
      xfer(1'b0, 1'b0, 1'b1, 8, '0, rd, er);
      chk("R6 signature after reset", rd, {SIG, 32'h0});
      m_off = 4;

      // R4 R5 R10 R1: sweep every item and size, past the end
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < ENTRIES; i++)
            for (int s = 1; s <= 8; s = s * 2) begin
               sel_sep((b << 14) | i | ((i % 2) << 15));
               for (int n = 0; n < e_len(b, i) / s + 2; n++)
                  read_sep(s, (m_off + s <= e_len(b, i)) ? "R4 R10 packed read" : "R5 padded read");
            end

      // R2: out-of-range indices read zero
      sel_sep(ENTRIES);
      read_sep(8, "R2 invalid index reads zero");
      read_sep(4, "R2 invalid stays invalid");
      sel_sep(16'h7fff);
      read_sep(8, "R2 invalid arch index reads zero");
      sel_sep(16'h4001);
      read_sep(2, "R2 valid after invalid");

      // R3: re-select restarts
      sel_sep(5);
      read_sep(4, "R3 first pass");
      sel_sep(5);
      read_sep(4, "R3 restart from zero");

      // R7: data writes ignored
      sel_sep(4);
      read_sep(2, "R7 before write");
      xfer(1'b0, 1'b1, 1'b1, 8, 64'hffff_ffff_ffff_ffff, rd, er);
      chk("R7 data write no error", 64'(er), 64'd0);
      chk("R7 data write no data", rd, 64'd0);
      read_sep(2, "R7 position unchanged by write");

      // R8: split layout rejections
      xfer(1'b0, 1'b0, 1'b0, 2, '0, rd, er);
      chk("R8 selector read rejected", 64'(er), 64'd1);
      chk("R8 selector read zero", rd, 64'd0);
      xfer(1'b0, 1'b1, 1'b0, 1, 64'd1, rd, er);
      chk("R8 1-byte selector write rejected", 64'(er), 64'd1);
      xfer(1'b0, 1'b1, 1'b0, 4, 64'd1, rd, er);
      chk("R8 4-byte selector write rejected", 64'(er), 64'd1);
      xfer(1'b0, 1'b0, 1'b1, 3, '0, rd, er);
      chk("R8 size 3 data read rejected", 64'(er), 64'd1);
      chk("R8 rejected read zero", rd, 64'd0);
      read_sep(2, "R8 rejections left position alone");

      // R9: combined layout (reset state: signature)
      xfer(1'b1, 1'b0, 1'b0, 1, '0, rd, er);
      chk("R9 byte read at offset 0", rd, 64'(SIG[31:24]));
      xfer(1'b1, 1'b0, 1'b1, 1, '0, rd, er);
      chk("R9 byte read at offset 1", rd, 64'(SIG[23:16]));
      xfer(1'b1, 1'b1, 1'b0, 2, 64'h0000_4003, rd, er);
      chk("R9 2-byte write selects", 64'(er), 64'd0);
      xfer(1'b1, 1'b0, 1'b0, 1, '0, rd, er);
      chk("R9 first byte of selected item", rd, 64'(e_byte(1, 3, 0)));
      xfer(1'b1, 1'b1, 1'b1, 1, 64'h55, rd, er);
      chk("R9 byte write ignored no error", 64'(er), 64'd0);
      xfer(1'b1, 1'b0, 1'b0, 2, '0, rd, er);
      chk("R9 2-byte read rejected", 64'(er), 64'd1);
      chk("R9 rejected read zero", rd, 64'd0);
      xfer(1'b1, 1'b1, 1'b1, 2, 64'd0, rd, er);
      chk("R9 2-byte write at offset 1 rejected", 64'(er), 64'd1);
      xfer(1'b1, 1'b1, 1'b0, 4, 64'd0, rd, er);
      chk("R9 4-byte write rejected", 64'(er), 64'd1);
      xfer(1'b1, 1'b0, 1'b1, 1, '0, rd, er);
      chk("R9 stream continues after rejects", rd, 64'(e_byte(1, 3, 1)));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule